// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a fixed-width instruction word into the steering signals of a single-cycle datapath. It selects the destination register field, picks the ALU's second operand, chooses the write-back source, enables register and data-memory writes, enables memory reads, and flags conditional branches and unconditional jumps. It is purely combinational: every output follows its inputs within the same cycle, and there is no clock, reset or handshake.

The ALU operation is chosen in two steps. A main decoder looks only at the opcode. It yields the control flags and a 2-bit operation class. A local ALU-control stage then takes the class. For load, store, add-immediate and jump it forces add. For branch-on-equal it forces subtract. Only for register-format instructions does it consult the function field. Anything outside the supported set falls back to a safe result: no writes, no branch, no jump, and the add operation.

Top module: `instr_ctrl_decode`

## Requirements
- R1: Opcode 0 (register format) with a known function code drives dest-select=1, imm-operand=0, mem-to-reg=0, reg-write=1, mem-read=0, mem-write=0, branch=0, jump=0 and class 2'b10.
- R2: Opcode 35 (load word) drives dest-select=0, imm-operand=1, mem-to-reg=1, reg-write=1, mem-read=1, mem-write=0, branch=0, jump=0, class 2'b00 and ALU code 4'b0010 (add).
- R3: Opcode 43 (store word) drives imm-operand=1 and mem-write=1. It also drives reg-write=0, mem-read=0, branch=0 and jump=0, and its don't-care fields (dest-select, mem-to-reg) are 0. Class is 2'b00 and the ALU code is add.
- R4: Opcode 4 (branch on equal) drives branch=1 and every other flag 0, class 2'b01, and ALU code 4'b0110 (subtract).
- R5: Opcode 2 (jump) drives jump=1, every other flag 0, class 2'b00 and ALU code add. No other opcode raises jump.
- R6: Opcode 8 (add immediate) drives dest-select=0, imm-operand=1, mem-to-reg=0, reg-write=1, all memory, branch and jump flags 0, class 2'b00 and ALU code add.
- R7: With class 2'b10 the function field picks the ALU code: 6'b100100 gives 4'b0000 (AND), 6'b100101 gives 4'b0001 (OR), 6'b100000 gives 4'b0010 (add), 6'b100010 gives 4'b0110 (subtract), and 6'b101010 gives 4'b0111 (set-on-less-than).
- R8: When the class is not 2'b10, the function field has no effect on any output.
- R9: Any opcode other than 0, 2, 4, 8, 35 and 43 drives every flag to 0, class 2'b00 and ALU code add.
- R10: Opcode 0 with any other function code keeps the register-format flags, with one change: reg-write is 0. The ALU code is add.
- R11: Data-memory read and write are never both asserted, and mem-to-reg is asserted only together with mem-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the instruction |
| fn_i | input | 6 | Function field of the instruction |
| dst_rd_o | output | 1 | 1: write to the third register field; 0: write to the second |
| opb_imm_o | output | 1 | ALU second operand is the sign-extended immediate |
| wb_mem_o | output | 1 | Register write-back takes memory read data |
| rf_we_o | output | 1 | Register file write enable |
| dm_re_o | output | 1 | Data memory read enable |
| dm_we_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Conditional branch on equal operands |
| jmp_o | output | 1 | Unconditional jump |
| alu_cls_o | output | 2 | Operation class: 00 add, 01 subtract, 10 use function field |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The opcode override and the function-field lookup can both act on the same instruction word. The opcode alone must win whenever the class is not register-format. The bench provokes this by pairing every opcode with function codes that would mean subtract, set-on-less-than, OR or nonsense. It then requires the forced add or subtract result and unchanged flags. The second collision is a register-format opcode with an unknown function code, where write suppression and the add fallback must both appear in the same evaluation. The scoreboard compares the whole output vector for all 64 function values under opcode 0.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  parameter int OP_W  = 6;
  parameter int FN_W  = 6;
  parameter int ALU_W = 4;
  parameter int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD = 2'b00,
    CLS_SUB = 2'b01,
    CLS_FN  = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic dst_rd;
    logic opb_imm;
    logic wb_mem;
    logic rf_we;
    logic dm_re;
    logic dm_we;
    logic br_eq;
    logic jmp;
  } ctl_flags_t;

  localparam logic [OP_W-1:0] OPC_REG   = 6'd0;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'd2;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [ALU_W-1:0] ALU_AND = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [ALU_W-1:0] ALU_SLT = 4'b0111;
  localparam logic [ALU_W-1:0] ALU_NOR = 4'b1100;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] op,
  output ctl_flags_t     flags,
  output alu_cls_e       cls
);

  always_comb begin
    flags = '0;
    cls   = CLS_ADD;
    case (op)
      OPC_REG: begin
        flags.dst_rd = 1'b1;
        flags.rf_we  = 1'b1;
        cls          = CLS_FN;
      end
      OPC_LOAD: begin
        flags.opb_imm = 1'b1;
        flags.wb_mem  = 1'b1;
        flags.rf_we   = 1'b1;
        flags.dm_re   = 1'b1;
      end
      OPC_STORE: begin
        flags.opb_imm = 1'b1;
        flags.dm_we   = 1'b1;
      end
      OPC_BEQ: begin
        flags.br_eq = 1'b1;
        cls         = CLS_SUB;
      end
      OPC_JMP: begin
        flags.jmp = 1'b1;
      end
      OPC_ADDI: begin
        flags.opb_imm = 1'b1;
        flags.rf_we   = 1'b1;
      end
      default: begin
        flags = '0;
        cls   = CLS_ADD;
      end
    endcase
  end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int AW  = ALU_W
) (
  input  alu_cls_e       cls,
  input  logic [FNW-1:0] fn,
  output logic [AW-1:0]  alu_op,
  output logic           fn_ok
);

  always_comb begin
    alu_op = ALU_ADD;
    fn_ok  = 1'b1;
    case (cls)
      CLS_SUB: alu_op = ALU_SUB;
      CLS_FN: begin
        case (fn)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: begin
            alu_op = ALU_ADD;
            fn_ok  = 1'b0;
          end
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/instr_ctrl_decode.sv
module instr_ctrl_decode
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W,
  parameter int AW  = ALU_W,
  parameter int CW  = CLS_W
) (
  input  logic [OPW-1:0] op_i,
  input  logic [FNW-1:0] fn_i,
  output logic           dst_rd_o,
  output logic           opb_imm_o,
  output logic           wb_mem_o,
  output logic           rf_we_o,
  output logic           dm_re_o,
  output logic           dm_we_o,
  output logic           br_eq_o,
  output logic           jmp_o,
  output logic [CW-1:0]  alu_cls_o,
  output logic [AW-1:0]  alu_op_o
);

  ctl_flags_t flags;
  alu_cls_e   cls;
  logic       fn_ok;

  ctl_main_dec #(.OPW(OPW)) u_main (
    .op    (op_i),
    .flags (flags),
    .cls   (cls)
  );

  ctl_alu_dec #(.FNW(FNW), .AW(AW)) u_alu (
    .cls    (cls),
    .fn     (fn_i),
    .alu_op (alu_op_o),
    .fn_ok  (fn_ok)
  );

  // An unrecognised function code must not commit a register write.
  assign dst_rd_o  = flags.dst_rd;
  assign opb_imm_o = flags.opb_imm;
  assign wb_mem_o  = flags.wb_mem;
  assign rf_we_o   = flags.rf_we & fn_ok;
  assign dm_re_o   = flags.dm_re;
  assign dm_we_o   = flags.dm_we;
  assign br_eq_o   = flags.br_eq;
  assign jmp_o     = flags.jmp;
  assign alu_cls_o = cls;

endmodule

// File: rtl/ctl_dec_chk.sv
module ctl_dec_chk
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W,
  parameter int AW  = ALU_W,
  parameter int CW  = CLS_W
) (
  input logic [OPW-1:0] op_i,
  input logic [FNW-1:0] fn_i,
  input logic           dst_rd_o,
  input logic           opb_imm_o,
  input logic           wb_mem_o,
  input logic           rf_we_o,
  input logic           dm_re_o,
  input logic           dm_we_o,
  input logic           br_eq_o,
  input logic           jmp_o,
  input logic [CW-1:0]  alu_cls_o,
  input logic [AW-1:0]  alu_op_o
);

  logic known;
  assign known = !$isunknown({op_i, fn_i});

  always_comb begin
    if (known) begin
      p_mem_excl_r11: assert (!(dm_re_o && dm_we_o))
        else $error("memory read and write together");
      p_wb_needs_read_r11: assert (!wb_mem_o || dm_re_o)
        else $error("mem-to-reg without mem-read");
      p_jump_alone_r5: assert (!jmp_o || !(rf_we_o || dm_we_o || dm_re_o || br_eq_o))
        else $error("jump with other action");
      p_branch_sub_r4: assert (!br_eq_o || (alu_op_o == ALU_SUB && alu_cls_o == CLS_SUB))
        else $error("branch without subtract");
      p_fixed_class_r8: assert (alu_cls_o == CLS_FN || alu_op_o == ALU_ADD || alu_op_o == ALU_SUB)
        else $error("opcode class let function field through");
      p_rd_rtype_r1: assert (!dst_rd_o || alu_cls_o == CLS_FN)
        else $error("dest-select outside register format");
      p_bad_fn_r10: assert (!(alu_cls_o == CLS_FN && !rf_we_o) || alu_op_o == ALU_ADD)
        else $error("suppressed write without add fallback");
    end
  end

endmodule

bind instr_ctrl_decode ctl_dec_chk #(.OPW(OPW), .FNW(FNW), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/test_instr_ctrl_decode.sv
`timescale 1ns/1ps
module test_instr_ctrl_decode;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] op_i = 6'd63;
  logic [5:0] fn_i = 6'd0;
  logic dst_rd_o, opb_imm_o, wb_mem_o, rf_we_o, dm_re_o, dm_we_o, br_eq_o, jmp_o;
  logic [1:0] alu_cls_o;
  logic [3:0] alu_op_o;

  instr_ctrl_decode i_instr_ctrl_decode (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [13:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] stim_q[$];

  // {dst,imm,wbm,we,re,mwe,br,jmp,cls[1:0],alu[3:0]}
  function automatic logic [13:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [3:0] a;
    bit ok;
    ok = 1'b1;
    case (fn)
      6'b100000: a = 4'b0010;
      6'b100010: a = 4'b0110;
      6'b100100: a = 4'b0000;
      6'b100101: a = 4'b0001;
      6'b101010: a = 4'b0111;
      default: begin a = 4'b0010; ok = 1'b0; end
    endcase
    case (op)
      6'd0:  return ok ? {8'b1001_0000, 2'b10, a} : {8'b1000_0000, 2'b10, 4'b0010};
      6'd35: return {8'b0111_1000, 2'b00, 4'b0010};
      6'd43: return {8'b0100_0100, 2'b00, 4'b0010};
      6'd4:  return {8'b0000_0010, 2'b01, 4'b0110};
      6'd2:  return {8'b0000_0001, 2'b00, 4'b0010};
      6'd8:  return {8'b0101_0000, 2'b00, 4'b0010};
      default: return {8'b0000_0000, 2'b00, 4'b0010};
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'd0: begin
        case (fn)
          6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010: return "R1/R7";
          default: return "R10";
        endcase
      end
      6'd35: return "R2/R8";
      6'd43: return "R3/R8";
      6'd4:  return "R4/R8";
      6'd2:  return "R5/R8";
      6'd8:  return "R6/R8";
      default: return "R9/R11";
    endcase
  endfunction

  task automatic drive(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    #1;
    op_i = op;
    fn_i = fn;
    exp_q.push_back(model(op, fn));
    tag_q.push_back(tag_of(op, fn));
    stim_q.push_back({op, fn});
  endtask

  // Monitor: compares at the falling edge, after the inputs have settled.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [13:0] e, g;
      string t;
      logic [11:0] s;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      s = stim_q.pop_front();
      g = {dst_rd_o, opb_imm_o, wb_mem_o, rf_we_o, dm_re_o, dm_we_o,
           br_eq_o, jmp_o, alu_cls_o, alu_op_o};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s op=%0d fn=%b actual=%b expected=%b", t, s[11:6], s[5:0], g, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [5:0] probe [8];
    probe[0] = 6'b100000; probe[1] = 6'b100010; probe[2] = 6'b100100;
    probe[3] = 6'b100101; probe[4] = 6'b101010; probe[5] = 6'b000000;
    probe[6] = 6'b111111; probe[7] = 6'b100111;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Idle vector: unused opcode gives all flags low and add (R9).
    drive(6'd63, 6'd0);
    // R7 function map and R10 fallback: every function code under opcode 0.
    for (int f = 0; f < 64; f++) drive(6'd0, 6'(f));
    // R1..R6, R8, R9: every opcode against functions that would mean other ops.
    for (int o = 0; o < 64; o++)
      for (int k = 0; k < 8; k++) drive(6'(o), probe[k]);
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R1 pending results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule